// File: doc/BRIEF.md
# SDRAM Command Protocol Checker

This block sits passively beside the command pins of a synchronous DRAM interface and watches every rising clock edge. It turns the row strobe, column strobe, write enable and clock enable levels into a command, keeps a copy of the mode word loaded by the last legal mode register set, and keeps track of which banks hold an open row. A command that breaks one of the ordering rules makes a one-cycle error pulse, together with a code that names the broken rule.

The block also presents the decoded contents of the captured mode word as plain outputs: burst length as a count, the burst ordering, CAS latency and the write burst policy. Logic that reads these outputs then needs no mode register of its own. The block drives nothing onto the DRAM bus. It does not check data, refresh timing or electrical timing.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from {ras_n, cas_n, we_n} at each rising edge: 011 opens a row in bank `bank` (activate), 101 is a read, 100 is a write, 010 is a precharge, 000 is a mode register set. All other codes cause no state change and no error.
- R2: A legal mode set loads the mode word from `addr`, and the outputs show the new values from the following cycle. `burst_len` shows 1, 2, 4 or 8 for A2:A0 = 000, 001, 010 or 011, and 0 for any code with A2 set. `burst_interleave` = A3. `cas_latency` = A6:A4. `single_write` = A9.
- R3: `err_valid` goes high for exactly the cycle after the edge of an offending command, and `err_code` carries the rule number at the same time. With no violation, `err_valid` is 0 and `err_code` is 0.
- R4: A mode set while any bank is open gives code 1 and leaves the mode outputs unchanged.
- R5: A mode set when `cke` was low at the previous rising edge gives code 2 and leaves the mode outputs unchanged. Code 1 takes priority over code 2.
- R6: An activate before the first legal mode set since reset gives code 3, and the bank stays closed.
- R7: A read or write to a bank with no open row gives code 4.
- R8: A read or write to an open bank fewer than TRCD clocks after its activate gives code 5. With TRCD = 3, an access 1 or 2 clocks after the activate is flagged and one 3 clocks after it is accepted.
- R9: A precharge with A10 low closes only the bank on `bank`. A precharge with A10 high closes every bank.
- R10: After reset: no error, mode word zero (`burst_len` 1, sequential, `cas_latency` 0, `single_write` 0), all banks closed, no mode set seen, and `cke` treated as low on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable level on the bus |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W (2) | Bank select |
| addr | input | ADDR_W (13) | Address bus, carries the mode word on a mode set |
| err_valid | output | 1 | One-cycle violation pulse |
| err_code | output | 3 | Number of the violated rule (1 to 5) |
| burst_len | output | 4 | Burst length in beats (0 for a reserved code) |
| burst_interleave | output | 1 | 1 for interleaved ordering |
| cas_latency | output | 3 | CAS latency field |
| single_write | output | 1 | 1 when writes are single beat |

## Verification
The hardest case to reach is the mode-set CKE rule. It fires only when clock enable was low on the edge before, and only while no bank is open, because the open-bank rule outranks it. The stimulus table reaches it by closing every bank with a precharge-all, idling one cycle with `cke` low, and then issuing the mode set. The next row repeats that mode set with `cke` high, which confirms that the word is taken only then. The tRCD window is walked one clock at a time at offsets 1, 2 and 3 after a single activate.

// File: rtl/sdcmon_pkg.sv
package sdcmon_pkg;

    // Command code as {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_MODE_SET  = 3'b000,
        CMD_REFRESH   = 3'b001,
        CMD_PRECHARGE = 3'b010,
        CMD_ACTIVATE  = 3'b011,
        CMD_WRITE     = 3'b100,
        CMD_READ      = 3'b101,
        CMD_STOP      = 3'b110,
        CMD_NOP       = 3'b111
    } cmd_e;

    // Violation codes, lower value wins within one command class
    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_MODE_OPEN  = 3'd1,
        ERR_MODE_CKE   = 3'd2,
        ERR_ACT_NOMODE = 3'd3,
        ERR_COL_CLOSED = 3'd4,
        ERR_COL_TRCD   = 3'd5
    } err_e;

    typedef struct packed {
        logic       single_write;
        logic [2:0] cas_lat;
        logic       interleave;
        logic [2:0] bl_code;
    } mode_t;

    localparam int MODE_BL_LSB = 0;
    localparam int MODE_BT_BIT = 3;
    localparam int MODE_CL_LSB = 4;
    localparam int MODE_WB_BIT = 9;
    localparam int PRE_ALL_BIT = 10;

endpackage

// File: rtl/sdcmon_decode.sv
module sdcmon_decode
    import sdcmon_pkg::*;
(
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd,
    output logic is_mode_set,
    output logic is_activate,
    output logic is_column,
    output logic is_precharge
);

    always_comb begin
        cmd          = cmd_e'({ras_n, cas_n, we_n});
        is_mode_set  = 1'b0;
        is_activate  = 1'b0;
        is_column    = 1'b0;
        is_precharge = 1'b0;
        unique case (cmd)
            CMD_MODE_SET:        is_mode_set  = 1'b1;
            CMD_ACTIVATE:        is_activate  = 1'b1;
            CMD_READ, CMD_WRITE: is_column    = 1'b1;
            CMD_PRECHARGE:       is_precharge = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sdcmon_mode_reg.sv
module sdcmon_mode_reg
    import sdcmon_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] word,
    output logic              mode_seen,
    output logic [3:0]        burst_len,
    output logic              burst_interleave,
    output logic [2:0]        cas_latency,
    output logic              single_write
);

    typedef struct packed {
        logic  seen;
        mode_t mode;
    } mreg_t;

    mreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.seen              = 1'b1;
            st_d.mode.bl_code      = word[MODE_BL_LSB +: 3];
            st_d.mode.interleave   = word[MODE_BT_BIT];
            st_d.mode.cas_lat      = word[MODE_CL_LSB +: 3];
            st_d.mode.single_write = word[MODE_WB_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q.mode.bl_code)
            3'b000:  burst_len = 4'd1;
            3'b001:  burst_len = 4'd2;
            3'b010:  burst_len = 4'd4;
            3'b011:  burst_len = 4'd8;
            default: burst_len = 4'd0;
        endcase
    end

    assign mode_seen        = st_q.seen;
    assign burst_interleave = st_q.mode.interleave;
    assign cas_latency      = st_q.mode.cas_lat;
    assign single_write     = st_q.mode.single_write;

    // R4, R5: without a legal load the captured word does not move
    p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.mode));

    // R2: a load is always reflected on the next cycle
    p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cas_latency == $past(word[MODE_CL_LSB +: 3])) && mode_seen);

endmodule

// File: rtl/sdcmon_bank_track.sv
module sdcmon_bank_track #(
    parameter int NUM_BANKS = 4,
    parameter int TRCD      = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int CNT_W    = $clog2(TRCD + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_en,
    input  logic                 pre_en,
    input  logic                 pre_all,
    input  logic [BANK_W-1:0]    bank_sel,
    output logic [NUM_BANKS-1:0] open,
    output logic [NUM_BANKS-1:0] rcd_busy
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRCD - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [NUM_BANKS-1:0]            open;
        logic [NUM_BANKS-1:0][CNT_W-1:0] cnt;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (st_q.cnt[b] != '0)
                st_d.cnt[b] = st_q.cnt[b] - CNT_ONE;
            if (pre_en && (pre_all || bank_sel == BANK_W'(b)))
                st_d.open[b] = 1'b0;
            if (act_en && bank_sel == BANK_W'(b)) begin
                st_d.open[b] = 1'b1;
                st_d.cnt[b]  = CNT_LOAD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open = st_q.open;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_busy
        assign rcd_busy[g] = (st_q.cnt[g] != '0);
    end

    // R1: an accepted activate opens the addressed bank
    p_act_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |=> open[$past(bank_sel)]);

    // R9: precharge-all leaves no bank open
    p_pre_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && pre_all) |=> (open == '0));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdcmon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int TRCD      = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    output logic              err_valid,
    output logic [2:0]        err_code,
    output logic [3:0]        burst_len,
    output logic              burst_interleave,
    output logic [2:0]        cas_latency,
    output logic              single_write
);

    typedef struct packed {
        logic cke_prev;
        logic err_valid;
        err_e err_code;
    } top_st_t;

    cmd_e                 cmd;
    logic                 is_mode_set, is_activate, is_column, is_precharge;
    logic                 mode_seen;
    logic [NUM_BANKS-1:0] open;
    logic [NUM_BANKS-1:0] rcd_busy;
    logic                 load_mode, act_ok;
    err_e                 verdict;
    top_st_t              st_d, st_q;

    sdcmon_decode u_decode (
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .cmd          (cmd),
        .is_mode_set  (is_mode_set),
        .is_activate  (is_activate),
        .is_column    (is_column),
        .is_precharge (is_precharge)
    );

    sdcmon_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
        .clk              (clk),
        .rst_n            (rst_n),
        .load             (load_mode),
        .word             (addr),
        .mode_seen        (mode_seen),
        .burst_len        (burst_len),
        .burst_interleave (burst_interleave),
        .cas_latency      (cas_latency),
        .single_write     (single_write)
    );

    sdcmon_bank_track #(.NUM_BANKS(NUM_BANKS), .TRCD(TRCD)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_en   (act_ok),
        .pre_en   (is_precharge),
        .pre_all  (addr[PRE_ALL_BIT]),
        .bank_sel (bank),
        .open     (open),
        .rcd_busy (rcd_busy)
    );

    // Rule evaluation for the command on the bus this cycle
    always_comb begin
        verdict   = ERR_NONE;
        load_mode = 1'b0;
        act_ok    = 1'b0;
        if (is_mode_set) begin
            if (|open)               verdict = ERR_MODE_OPEN;
            else if (!st_q.cke_prev) verdict = ERR_MODE_CKE;
            else                     load_mode = 1'b1;
        end
        if (is_activate) begin
            if (!mode_seen) verdict = ERR_ACT_NOMODE;
            else            act_ok  = 1'b1;
        end
        if (is_column) begin
            if (!open[bank])         verdict = ERR_COL_CLOSED;
            else if (rcd_busy[bank]) verdict = ERR_COL_TRCD;
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.cke_prev  = cke;
        st_d.err_valid = (verdict != ERR_NONE);
        st_d.err_code  = verdict;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cke_prev: 1'b0, err_valid: 1'b0, err_code: ERR_NONE};
        else        st_q <= st_d;
    end

    assign err_valid = st_q.err_valid;
    assign err_code  = st_q.err_code;

    // R4: mode set over an open bank is reported with code 1
    p_mode_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mode_set && (|open)) |=> (err_valid && err_code == 3'd1));

    // R5: mode set after a low clock enable, banks idle, reports code 2
    p_mode_cke_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mode_set && (open == '0) && !$past(cke)) |=> (err_valid && err_code == 3'd2));

    // R6: activate with no prior mode set reports code 3
    p_act_nomode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_activate && !mode_seen) |=> (err_valid && err_code == 3'd3));

    // R7: column access to an idle bank reports code 4
    p_col_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_column && !open[bank]) |=> (err_valid && err_code == 3'd4));

    // R3: a quiet bus cycle yields no error on the next cycle
    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP) |=> (!err_valid && err_code == 3'd0));

endmodule

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  bank = '0;
    logic [12:0] addr = '0;
    logic        err_valid;
    logic [2:0]  err_code;
    logic [3:0]  burst_len;
    logic        burst_interleave;
    logic [2:0]  cas_latency;
    logic        single_write;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sdram_cmd_monitor dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cke              (cke),
        .ras_n            (ras_n),
        .cas_n            (cas_n),
        .we_n             (we_n),
        .bank             (bank),
        .addr             (addr),
        .err_valid        (err_valid),
        .err_code         (err_code),
        .burst_len        (burst_len),
        .burst_interleave (burst_interleave),
        .cas_latency      (cas_latency),
        .single_write     (single_write)
    );

    // Row: {cke, {ras_n,cas_n,we_n}, bank, addr, expected code, expected burst_len}
    localparam int NV = 18;
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 3'b111, 2'd0, 13'h000, 3'd0, 4'd1},  // R1 idle
        {1'b1, 3'b011, 2'd0, 13'h000, 3'd3, 4'd1},  // R6 activate before mode set
        {1'b1, 3'b000, 2'd0, 13'h032, 3'd0, 4'd4},  // R2 legal mode set, BL4
        {1'b1, 3'b011, 2'd1, 13'h000, 3'd0, 4'd4},  // R1 activate bank1
        {1'b1, 3'b101, 2'd1, 13'h000, 3'd5, 4'd4},  // R8 offset 1
        {1'b1, 3'b101, 2'd1, 13'h000, 3'd5, 4'd4},  // R8 offset 2
        {1'b1, 3'b101, 2'd1, 13'h000, 3'd0, 4'd4},  // R8 offset 3 ok
        {1'b1, 3'b100, 2'd2, 13'h000, 3'd4, 4'd4},  // R7 write to idle bank
        {1'b1, 3'b000, 2'd0, 13'h22B, 3'd1, 4'd4},  // R4 mode set, bank open
        {1'b1, 3'b010, 2'd1, 13'h000, 3'd0, 4'd4},  // R9 single precharge
        {1'b1, 3'b011, 2'd2, 13'h000, 3'd0, 4'd4},
        {1'b1, 3'b011, 2'd3, 13'h000, 3'd0, 4'd4},
        {1'b1, 3'b010, 2'd0, 13'h400, 3'd0, 4'd4},  // R9 precharge all
        {1'b1, 3'b101, 2'd3, 13'h000, 3'd4, 4'd4},  // R9 bank3 now closed
        {1'b0, 3'b111, 2'd0, 13'h000, 3'd0, 4'd4},  // cke low
        {1'b1, 3'b000, 2'd0, 13'h22B, 3'd2, 4'd4},  // R5 mode set after cke low
        {1'b1, 3'b000, 2'd0, 13'h22B, 3'd0, 4'd8},  // R2 legal, BL8
        {1'b1, 3'b100, 2'd0, 13'h000, 3'd4, 4'd8}   // R7
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic [2:0] cmd,
                        input logic [1:0] b, input logic [12:0] a);
        @(negedge clk);
        cke = c;
        {ras_n, cas_n, we_n} = cmd;
        bank = b;
        addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic check_err(input string req, input int code);
        check(req, int'(err_code), code);
        check(req, int'(err_valid), (code != 0) ? 1 : 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        check_err("R10", 0);
        check("R10", int'(burst_len), 1);
        check("R10", int'(cas_latency), 0);
        check("R10", int'(burst_interleave), 0);
        check("R10", int'(single_write), 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][25], VEC[i][24:22], VEC[i][21:20], VEC[i][19:7]);
            check_err("R3 table", int'(VEC[i][6:4]));
            check("R2 table", int'(burst_len), int'(VEC[i][3:0]));
        end

        // R2 other fields of word 0x22B
        check("R2", int'(burst_interleave), 1);
        check("R2", int'(cas_latency), 2);
        check("R2", int'(single_write), 1);

        // R2 reserved burst code
        step(1'b1, 3'b000, 2'd0, 13'h034);
        check_err("R2", 0);
        check("R2", int'(burst_len), 0);
        check("R2", int'(cas_latency), 3);
        step(1'b1, 3'b001, 2'd0, 13'h000);  // R1 refresh: no error
        check_err("R1", 0);

        // R10 reset clears mode and history
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10", int'(burst_len), 1);
        check("R10", int'(single_write), 0);
        check_err("R10", 0);
        step(1'b1, 3'b011, 2'd0, 13'h000);
        check_err("R6", 3);
        step(1'b1, 3'b000, 2'd0, 13'h001);  // R6 flagged activate left bank closed
        check_err("R6", 0);
        check("R2", int'(burst_len), 2);

        // R9 single-bank precharge leaves other banks open
        step(1'b1, 3'b011, 2'd0, 13'h000);
        step(1'b1, 3'b011, 2'd1, 13'h000);
        step(1'b1, 3'b111, 2'd0, 13'h000);
        step(1'b1, 3'b111, 2'd0, 13'h000);
        step(1'b1, 3'b111, 2'd0, 13'h000);
        step(1'b1, 3'b010, 2'd0, 13'h000);
        check_err("R9", 0);
        step(1'b1, 3'b100, 2'd1, 13'h000);
        check_err("R9", 0);
        step(1'b1, 3'b100, 2'd0, 13'h000);
        check_err("R9", 4);
        step(1'b1, 3'b111, 2'd0, 13'h000);
        check_err("R3", 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule